// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block pushes a configuration bitstream from a bus master into a target FPGA over a slave-serial link. Software works through four 32-bit registers on a Wishbone slave port. It stages the byte count and an end-of-stream mark for an entry, then writes the data word, and that pushes the entry into a 16-deep FIFO. It can watch the FIFO level and full flag. It starts a load and reads back whether the load finished and whether it failed.

A divider turns the system clock into a tick. Each tick moves the configuration clock by one phase. On start the sequencer holds the program line low for a fixed number of ticks, releases it, and waits for the target to raise init. It then drains the FIFO one entry at a time and shifts 8 to 32 bits per entry, in the bit order that software chose. After the marked entry it keeps the clock running until the target raises done. The init wait and the done wait are both guarded by a tick timeout. Both target inputs are passed through two-flop synchronizers.

Top module: `cfg_loader`

## Requirements
- R1: After reset, program (active low) is high, the configuration clock is high, serial data is 0, the mode bus is 2'b11 and suspend is 0. The control register (word 0) reads 0 and the FIFO status register (word 1) reads 0x2: bit 1 is empty, bit 0 is full, and bits 12:8 hold the level.
- R2: Each strobe is acknowledged with a single-cycle ack in the cycle after the strobe, and read data is valid with that ack.
- R3: Writing word 3 pushes an entry made of that data word and the staged word 2 (bits 1:0 = valid bytes minus one, bit 2 = last). The full flag rises at 16 entries, and a push while full is dropped: the level stays 16 and the entry is never sent.
- R4: Writing word 0 with bit 1 (start) set while idle drives program low. The line stays low for PROG_TICKS ticks, between (PROG_TICKS-1)*CLK_DIV+1 and PROG_TICKS*CLK_DIV system cycles, and the configuration clock stays high meanwhile.
- R5: After program is released, no clock edge is produced until the synchronized init is high. If init stays low for TIMEOUT_TICKS ticks, the load ends with done (bit 4) and error (bit 5) set and no clock edge sent.
- R6: Each entry sends exactly 8*(count+1) bits. A bit changes only while the clock is low and is held across its rising edge. When bit 2 of the start write is 1, bits go out from bit 31 downward; when it is 0, from bit 0 upward.
- R7: After the last-marked entry the clock keeps toggling until the target raises done. The load then ends with done=1 and error=0, the FIFO is empty and busy (bit 3) is 0.
- R8: If done does not rise within TIMEOUT_TICKS ticks after the last entry, the load ends with done=1 and error=1.
- R9: Writing word 0 with bit 0 (soft reset) set flushes the FIFO, clears done and error, releases program, and returns the sequencer to idle, even in the middle of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| wbCyc | input | 1 | Bus cycle |
| wbStb | input | 1 | Bus strobe |
| wbWe | input | 1 | Write enable |
| wbAdr | input | 2 | Word address |
| wbDatIn | input | 32 | Write data |
| wbDatOut | output | 32 | Read data |
| wbAck | output | 1 | Acknowledge |
| tgtCclk | output | 1 | Configuration clock |
| tgtDin | output | 1 | Serial configuration data |
| tgtProgN | output | 1 | Program request, active low |
| tgtInitN | input | 1 | Target init, active low |
| tgtDone | input | 1 | Target done |
| tgtSuspend | output | 1 | Suspend, held low |
| tgtMode | output | 2 | Mode select, held 2'b11 |

## Verification
The hardest case to reach is the interaction of the FIFO boundary with the sequencer. Software must fill all sixteen entries before the engine can take any of them, and the dropped seventeenth push can only be seen by the missing bits and by a level that reads zero after the load. The bench fills the FIFO before issuing start, so the engine is held back by program and init. A modelled target then answers with init and done, or stays silent to force each timeout. The stream it captures is compared against a bit list that the bench builds for every byte count in both bit orders.

// File: rtl/loader_pkg.sv
package loader_pkg;
  localparam int WORD_W = 32;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_META = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int CTRL_SRST = 0;
  localparam int CTRL_START = 1;
  localparam int CTRL_MSB = 2;
  localparam int CTRL_BUSY = 3;
  localparam int CTRL_DONE = 4;
  localparam int CTRL_ERR = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_WAIT_INIT, ST_FETCH, ST_SHIFT, ST_WAIT_DONE
  } loaderState_t;

  typedef struct packed {
    logic flush;
    logic push;
    logic pop;
    logic emitBit;
    logic cclkLow;
    logic cclkHigh;
  } loaderStrobes_t;
endpackage

// File: rtl/loader_sync.sv
module loader_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= {stage[STAGES-2:0], asyncIn};
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/loader_datapath.sv
module loader_datapath import loader_pkg::*; #(
  parameter int CLK_DIV = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  localparam int DIV_W = $clog2(CLK_DIV),
  localparam int PTR_W = $clog2(FIFO_DEPTH),
  localparam int LEVEL_W = PTR_W + 1,
  localparam int ENTRY_W = WORD_W + 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  loaderStrobes_t     strobes,
  input  logic               msbFirst,
  input  logic [WORD_W-1:0]  pushWord,
  input  logic [2:0]         pushMeta,
  input  logic               initNRaw,
  input  logic               doneRaw,
  output logic               tick,
  output logic               initHigh,
  output logic               doneHigh,
  output logic [2:0]         headMeta,
  output logic               fifoFull,
  output logic               fifoEmpty,
  output logic [LEVEL_W-1:0] fifoLevel,
  output logic               cclk,
  output logic               din
);
  logic [DIV_W-1:0] divCnt;
  logic [ENTRY_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [WORD_W-1:0] shReg;
  logic doPush, doPop;

  // tick generator
  assign tick = (divCnt == DIV_W'(CLK_DIV - 1));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // target input synchronizers
  loader_sync #(.STAGES(SYNC_STAGES)) i_syncInit (
    .clk(clk), .rstN(rstN), .asyncIn(initNRaw), .syncOut(initHigh));
  loader_sync #(.STAGES(SYNC_STAGES)) i_syncDone (
    .clk(clk), .rstN(rstN), .asyncIn(doneRaw), .syncOut(doneHigh));

  // entry FIFO
  assign fifoFull  = (fifoLevel == LEVEL_W'(FIFO_DEPTH));
  assign fifoEmpty = (fifoLevel == '0);
  assign doPush = strobes.push && !fifoFull && !strobes.flush;
  assign doPop  = strobes.pop && !fifoEmpty && !strobes.flush;
  assign headMeta = mem[rdPtr][ENTRY_W-1:WORD_W];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {pushMeta, pushWord};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fifoLevel <= '0;
    end else if (strobes.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fifoLevel <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fifoLevel <= fifoLevel + 1'b1;
        2'b01:   fifoLevel <= fifoLevel - 1'b1;
        default: fifoLevel <= fifoLevel;
      endcase
    end
  end

  // serializer and configuration clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      din <= 1'b0;
      cclk <= 1'b1;
    end else if (strobes.flush) begin
      din <= 1'b0;
      cclk <= 1'b1;
    end else begin
      if (doPop) begin
        shReg <= mem[rdPtr][WORD_W-1:0];
      end else if (strobes.emitBit) begin
        din <= msbFirst ? shReg[WORD_W-1] : shReg[0];
        shReg <= msbFirst ? {shReg[WORD_W-2:0], 1'b0} : {1'b0, shReg[WORD_W-1:1]};
      end
      if (strobes.cclkLow)       cclk <= 1'b0;
      else if (strobes.cclkHigh) cclk <= 1'b1;
    end
  end
endmodule

// File: rtl/loader_ctrl.sv
module loader_ctrl import loader_pkg::*; #(
  parameter int PROG_TICKS = 32,
  parameter int TIMEOUT_TICKS = 100000,
  parameter int LEVEL_W = 5,
  localparam int CNT_MAX = (TIMEOUT_TICKS > PROG_TICKS) ? TIMEOUT_TICKS : PROG_TICKS,
  localparam int CNT_W = $clog2(CNT_MAX + 1),
  localparam int BITS_W = $clog2(WORD_W) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wbCyc,
  input  logic               wbStb,
  input  logic               wbWe,
  input  logic [1:0]         wbAdr,
  input  logic [2:0]         wrBits,
  output logic [WORD_W-1:0]  wbDatOut,
  output logic               wbAck,
  input  logic               tick,
  input  logic               initHigh,
  input  logic               doneHigh,
  input  logic               cclkNow,
  input  logic [2:0]         headMeta,
  input  logic               fifoFull,
  input  logic               fifoEmpty,
  input  logic [LEVEL_W-1:0] fifoLevel,
  output loaderStrobes_t     strobes,
  output logic               msbFirst,
  output logic [2:0]         pushMeta,
  output logic               progN
);
  loaderState_t state;
  logic [CNT_W-1:0] tickCnt;
  logic [BITS_W-1:0] bitsLeft;
  logic lastFlag, doneFlag, errFlag;
  logic access, wrEn, softRst, startReq, progEnd, tmoHit;
  logic [WORD_W-1:0] readMux;

  assign access   = wbCyc && wbStb && !wbAck;
  assign wrEn     = access && wbWe;
  assign softRst  = wrEn && (wbAdr == REG_CTRL) && wrBits[CTRL_SRST];
  assign startReq = wrEn && (wbAdr == REG_CTRL) && wrBits[CTRL_START] && (state == ST_IDLE);
  assign progEnd  = (tickCnt == CNT_W'(PROG_TICKS - 1));
  assign tmoHit   = (tickCnt == CNT_W'(TIMEOUT_TICKS - 1));

  always_comb begin
    readMux = '0;
    case (wbAdr)
      REG_CTRL: begin
        readMux[CTRL_MSB]  = msbFirst;
        readMux[CTRL_BUSY] = (state != ST_IDLE);
        readMux[CTRL_DONE] = doneFlag;
        readMux[CTRL_ERR]  = errFlag;
      end
      REG_STAT: begin
        readMux[0] = fifoFull;
        readMux[1] = fifoEmpty;
        readMux[8 +: LEVEL_W] = fifoLevel;
      end
      REG_META: readMux[2:0] = pushMeta;
      default:  readMux = '0;
    endcase
  end

  always_comb begin
    strobes = '0;
    strobes.flush = softRst;
    strobes.push  = wrEn && (wbAdr == REG_DATA);
    if (!softRst) begin
      case (state)
        ST_FETCH: strobes.pop = !fifoEmpty;
        ST_SHIFT: begin
          if (tick) begin
            if (cclkNow) begin
              strobes.emitBit = (bitsLeft != '0);
              strobes.cclkLow = (bitsLeft != '0);
            end else begin
              strobes.cclkHigh = 1'b1;
            end
          end
        end
        ST_WAIT_DONE: begin
          if (doneHigh) begin
            strobes.cclkHigh = !cclkNow;
          end else if (tick) begin
            strobes.cclkHigh = !cclkNow;
            strobes.cclkLow  = cclkNow && !tmoHit;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tickCnt <= '0;
      bitsLeft <= '0;
      lastFlag <= 1'b0;
      doneFlag <= 1'b0;
      errFlag <= 1'b0;
      msbFirst <= 1'b0;
      pushMeta <= '0;
      progN <= 1'b1;
      wbAck <= 1'b0;
      wbDatOut <= '0;
    end else begin
      wbAck <= access;
      if (access) wbDatOut <= readMux;
      if (wrEn && wbAdr == REG_CTRL) msbFirst <= wrBits[CTRL_MSB];
      if (wrEn && wbAdr == REG_META) pushMeta <= wrBits;

      if (softRst) begin
        state <= ST_IDLE;
        tickCnt <= '0;
        progN <= 1'b1;
        doneFlag <= 1'b0;
        errFlag <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: if (startReq) begin
            state <= ST_PROG;
            progN <= 1'b0;
            tickCnt <= '0;
            doneFlag <= 1'b0;
            errFlag <= 1'b0;
          end
          ST_PROG: if (tick) begin
            if (progEnd) begin
              progN <= 1'b1;
              tickCnt <= '0;
              state <= ST_WAIT_INIT;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_WAIT_INIT: begin
            if (initHigh) begin
              state <= ST_FETCH;
            end else if (tick) begin
              if (tmoHit) begin
                state <= ST_IDLE;
                doneFlag <= 1'b1;
                errFlag <= 1'b1;
              end else begin
                tickCnt <= tickCnt + 1'b1;
              end
            end
          end
          ST_FETCH: if (!fifoEmpty) begin
            bitsLeft <= BITS_W'({1'b0, headMeta[1:0]} + 3'd1) << 3;
            lastFlag <= headMeta[2];
            state <= ST_SHIFT;
          end
          ST_SHIFT: if (tick) begin
            if (!cclkNow) begin
              bitsLeft <= bitsLeft - 1'b1;
            end else if (bitsLeft == '0) begin
              tickCnt <= '0;
              state <= lastFlag ? ST_WAIT_DONE : ST_FETCH;
            end
          end
          ST_WAIT_DONE: begin
            if (doneHigh) begin
              state <= ST_IDLE;
              doneFlag <= 1'b1;
            end else if (tick) begin
              if (tmoHit) begin
                state <= ST_IDLE;
                doneFlag <= 1'b1;
                errFlag <= 1'b1;
              end else begin
                tickCnt <= tickCnt + 1'b1;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader import loader_pkg::*; #(
  parameter int CLK_DIV = 4,
  parameter int PROG_TICKS = 32,
  parameter int TIMEOUT_TICKS = 100000,
  parameter int FIFO_DEPTH = 16,
  localparam int LEVEL_W = $clog2(FIFO_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wbCyc,
  input  logic        wbStb,
  input  logic        wbWe,
  input  logic [1:0]  wbAdr,
  input  logic [31:0] wbDatIn,
  output logic [31:0] wbDatOut,
  output logic        wbAck,
  output logic        tgtCclk,
  output logic        tgtDin,
  output logic        tgtProgN,
  input  logic        tgtInitN,
  input  logic        tgtDone,
  output logic        tgtSuspend,
  output logic [1:0]  tgtMode
);
  loaderStrobes_t strobes;
  logic tick, initHigh, doneHigh, msbFirst, fifoFull, fifoEmpty;
  logic [2:0] headMeta, pushMeta;
  logic [LEVEL_W-1:0] fifoLevel;

  assign tgtSuspend = 1'b0;
  assign tgtMode = 2'b11;

  loader_ctrl #(
    .PROG_TICKS(PROG_TICKS), .TIMEOUT_TICKS(TIMEOUT_TICKS), .LEVEL_W(LEVEL_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wrBits(wbDatIn[2:0]), .wbDatOut(wbDatOut), .wbAck(wbAck),
    .tick(tick), .initHigh(initHigh), .doneHigh(doneHigh), .cclkNow(tgtCclk),
    .headMeta(headMeta), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .fifoLevel(fifoLevel), .strobes(strobes), .msbFirst(msbFirst),
    .pushMeta(pushMeta), .progN(tgtProgN));

  loader_datapath #(
    .CLK_DIV(CLK_DIV), .FIFO_DEPTH(FIFO_DEPTH)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .msbFirst(msbFirst),
    .pushWord(wbDatIn), .pushMeta(pushMeta), .initNRaw(tgtInitN),
    .doneRaw(tgtDone), .tick(tick), .initHigh(initHigh), .doneHigh(doneHigh),
    .headMeta(headMeta), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .fifoLevel(fifoLevel), .cclk(tgtCclk), .din(tgtDin));
endmodule

// File: rtl/cfg_loader_checker.sv
module cfg_loader_checker (
  input logic clk,
  input logic rstN,
  input logic wbCyc,
  input logic wbStb,
  input logic wbAck,
  input logic tgtCclk,
  input logic tgtDin,
  input logic tgtProgN
);
  assert_ack_next_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbStb && !wbAck) |=> wbAck);

  assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    wbAck |=> !wbAck);

  assert_clock_idle_in_prog_R4: assert property (@(posedge clk) disable iff (!rstN)
    !tgtProgN |-> tgtCclk);

  assert_data_held_at_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tgtCclk) |-> $stable(tgtDin));

  assert_no_fall_in_prog_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tgtCclk) |-> tgtProgN);
endmodule

bind cfg_loader cfg_loader_checker i_checker (
  .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbAck(wbAck),
  .tgtCclk(tgtCclk), .tgtDin(tgtDin), .tgtProgN(tgtProgN));

// File: tb/test_cfg_loader.sv
module test_cfg_loader;
  localparam int DIV = 2;
  localparam int PTK = 4;
  localparam int TMO = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wbCyc = 1'b0, wbStb = 1'b0, wbWe = 1'b0;
  logic [1:0] wbAdr = '0;
  logic [31:0] wbDatIn = '0;
  logic [31:0] wbDatOut;
  logic wbAck, tgtCclk, tgtDin, tgtProgN, tgtSuspend;
  logic tgtInitN = 1'b1;
  logic tgtDone;
  logic [1:0] tgtMode;

  int total = 0, bad = 0, ackMiss = 0;
  bit initRespond = 1'b1, doneRespond = 1'b1, curMsb = 1'b0;
  logic expBits [0:1023];
  logic rxBits [0:1023];
  int expLen = 0, rxCount = 0, rises = 0, progLow = 0;
  logic progPrev = 1'b1;

  always #10 clk = ~clk;

  cfg_loader #(.CLK_DIV(DIV), .PROG_TICKS(PTK), .TIMEOUT_TICKS(TMO)) i_cfg_loader (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbDatIn(wbDatIn), .wbDatOut(wbDatOut), .wbAck(wbAck),
    .tgtCclk(tgtCclk), .tgtDin(tgtDin), .tgtProgN(tgtProgN), .tgtInitN(tgtInitN),
    .tgtDone(tgtDone), .tgtSuspend(tgtSuspend), .tgtMode(tgtMode));

  // target model: init handshake
  initial forever begin
    @(negedge tgtProgN);
    #1 tgtInitN = 1'b0;
    @(posedge tgtProgN);
    if (initRespond) begin
      repeat (5) @(posedge clk);
      #1 tgtInitN = 1'b1;
    end
  end

  // target model: capture bits on rising clock, raise done
  always @(posedge tgtCclk or negedge tgtProgN) begin
    if (!tgtProgN) begin
      rxCount <= 0;
      rises <= 0;
      tgtDone <= 1'b0;
    end else begin
      rises <= rises + 1;
      if (tgtInitN) begin
        if (rxCount < 1024) rxBits[rxCount] <= tgtDin;
        rxCount <= rxCount + 1;
        if (doneRespond && rxCount + 1 >= expLen + 3) tgtDone <= 1'b1;
      end
    end
  end
  initial tgtDone = 1'b0;

  // program-low duration in system cycles
  always @(posedge clk) begin
    progPrev <= tgtProgN;
    if (!tgtProgN) progLow <= progPrev ? 1 : progLow + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wbXfer(input bit we, input logic [1:0] adr, input logic [31:0] wdat,
                        output logic [31:0] rdat);
    @(negedge clk);
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = we; wbAdr = adr; wbDatIn = wdat;
    @(negedge clk);
    if (!wbAck) ackMiss++;
    rdat = wbDatOut;
    wbCyc = 1'b0; wbStb = 1'b0; wbWe = 1'b0;
  endtask

  task automatic wbWrite(input logic [1:0] adr, input logic [31:0] wdat);
    logic [31:0] dummy;
    wbXfer(1'b1, adr, wdat, dummy);
  endtask

  task automatic wbRead(input logic [1:0] adr, output logic [31:0] rdat);
    wbXfer(1'b0, adr, 32'h0, rdat);
  endtask

  task automatic addEntry(input logic [31:0] word, input int cnt, input bit last);
    wbWrite(2'd2, {29'b0, last, cnt[1:0]});
    wbWrite(2'd3, word);
    for (int i = 0; i < 8 * (cnt + 1); i++)
      expBits[expLen + i] = curMsb ? word[31 - i] : word[i];
    expLen += 8 * (cnt + 1);
  endtask

  task automatic prepare(input bit msb);
    wbWrite(2'd0, 32'h1);
    curMsb = msb;
    expLen = 0;
  endtask

  task automatic startLoad();
    wbWrite(2'd0, 32'h2 | (32'(curMsb) << 2));
  endtask

  task automatic waitEnd(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 4000; i++) begin
      wbRead(2'd0, st);
      if (st[4]) break;
    end
  endtask

  task automatic checkStream(input string req);
    int mism = 0;
    for (int i = 0; i < expLen; i++)
      if (rxBits[i] !== expBits[i]) mism++;
    check(rxCount >= expLen, {req, " bit count"}, rxCount, expLen);
    check(mism == 0, {req, " bit values"}, mism, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tgtProgN === 1'b1 && tgtCclk === 1'b1 && tgtDin === 1'b0, "R1 target lines",
          {tgtProgN, tgtCclk, tgtDin}, 3'b110);
    check(tgtMode === 2'b11 && tgtSuspend === 1'b0, "R1 mode/suspend", {tgtMode, tgtSuspend}, 3'b110);
    // R2 dedicated ack timing
    @(negedge clk);
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = 1'b0; wbAdr = 2'd1;
    check(wbAck === 1'b0, "R2 no early ack", wbAck, 0);
    @(negedge clk);
    check(wbAck === 1'b1, "R2 ack next cycle", wbAck, 1);
    check(wbDatOut === 32'h2, "R1 status after reset", wbDatOut, 32'h2);
    wbCyc = 1'b0; wbStb = 1'b0;
    @(negedge clk);
    check(wbAck === 1'b0, "R2 single ack", wbAck, 0);
    wbRead(2'd0, rd);
    check(rd === 32'h0, "R1 control after reset", rd, 0);

    // R6/R7 sweep over byte counts and bit order
    for (int msb = 0; msb < 2; msb++) begin
      for (int c = 0; c < 4; c++) begin
        prepare(msb[0]);
        for (int k = 0; k < 3; k++)
          addEntry(32'h9E3779B9 * (k + 1 + 3 * c) ^ (32'h5A5A0000 >> msb), (c + k) % 4, k == 2);
        startLoad();
        waitEnd(rd);
        check(rd[5:3] === 3'b010, "R7 done ok", rd[5:3], 3'b010);
        checkStream("R6");
        wbRead(2'd1, rd);
        check(rd[1] === 1'b1, "R7 fifo drained", rd, 2);
        check(progLow >= (PTK - 1) * DIV + 1 && progLow <= PTK * DIV, "R4 program width", progLow, PTK * DIV);
      end
    end

    // data pushed after start while waiting for init
    prepare(1'b1);
    startLoad();
    addEntry(32'hC0FFEE11, 3, 1'b0);
    addEntry(32'h12345678, 1, 1'b1);
    waitEnd(rd);
    check(rd[5:4] === 2'b01, "R7 late push done", rd[5:4], 1);
    checkStream("R6 late push");

    // R3 FIFO full and dropped push
    prepare(1'b0);
    for (int i = 0; i < 16; i++) addEntry(32'h01010101 * (i + 1), 0, i == 15);
    wbRead(2'd1, rd);
    check(rd[0] === 1'b1 && rd[12:8] === 5'd16, "R3 full at 16", rd, 32'h1001);
    wbWrite(2'd2, 32'h3);
    wbWrite(2'd3, 32'hDEADBEEF);
    wbRead(2'd1, rd);
    check(rd[12:8] === 5'd16, "R3 level after dropped push", rd[12:8], 16);
    startLoad();
    waitEnd(rd);
    checkStream("R3 stream");
    wbRead(2'd1, rd);
    check(rd[12:8] === 5'd0 && rd[1] === 1'b1, "R3 nothing left", rd, 2);

    // R8 done timeout
    prepare(1'b1);
    doneRespond = 1'b0;
    addEntry(32'hA5A5F00F, 2, 1'b1);
    startLoad();
    waitEnd(rd);
    check(rd[5:4] === 2'b11, "R8 done timeout error", rd[5:4], 3);
    checkStream("R8 stream");
    doneRespond = 1'b1;

    // R5 init timeout
    prepare(1'b0);
    initRespond = 1'b0;
    addEntry(32'h11112222, 3, 1'b1);
    startLoad();
    waitEnd(rd);
    check(rd[5:4] === 2'b11, "R5 init timeout error", rd[5:4], 3);
    check(rises == 0, "R5 no clock edges", rises, 0);

    // R9 soft reset mid-load
    prepare(1'b0);
    addEntry(32'h33334444, 3, 1'b1);
    startLoad();
    repeat (20) @(negedge clk);
    wbRead(2'd0, rd);
    check(rd[3] === 1'b1, "R9 busy before soft reset", rd[3], 1);
    wbWrite(2'd0, 32'h1);
    @(negedge clk);
    check(tgtProgN === 1'b1, "R9 program released", tgtProgN, 1);
    wbRead(2'd0, rd);
    check(rd[5:3] === 3'b000, "R9 status cleared", rd[5:3], 0);
    wbRead(2'd1, rd);
    check(rd === 32'h2, "R9 fifo flushed", rd, 2);
    initRespond = 1'b1;

    check(ackMiss == 0, "R2 ack on every access", ackMiss, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule